// File: doc/BRIEF.md
# Speculative Cache Line Tracker

This block keeps the tag and state of a small set-associative write-back data cache whose lines can hold uncommitted stores from an atomic region. Every line has valid, dirty and speculative flags, a tag and one data word that stands in for the line contents. A store issued inside a region marks its line speculative and dirty. Committed dirty data on that line is first copied out through an eviction port, so a later abort cannot lose it.

A commit strobe clears every speculative flag in a single cycle, and the lines become ordinary dirty data. A rollback strobe invalidates every speculative line in a single cycle. Speculative lines are never chosen for replacement. When a store misses in a set whose ways are all speculative, the block signals an overflow and performs the rollback itself.

Requests are answered one cycle after they are accepted. Load misses do not allocate, because refill is handled outside this block. Store misses allocate, and when they displace dirty data the eviction port carries that data out.

Top module: `spec_line_tracker`

## Requirements
- R1: After reset every line is invalid, every output is 0, and a load returns rsp_hit=0.
- R2: A load accepted in cycle n produces rsp_valid=1 in cycle n+1, with rsp_hit and rsp_rdata taken from the matching line, which may be speculative. On a miss, rsp_hit=0 and rsp_rdata=0, no state changes and vb_valid stays 0. Address bits below log2(LINE_BYTES) are ignored, the next log2(SETS) bits select the set, and the remaining high bits form the tag.
- R3: A store hit overwrites the data and sets dirty. A store miss installs the line in the lowest-numbered invalid way, or if no way is invalid, in the lowest-numbered non-speculative way. A valid dirty line displaced this way is sent out on the eviction port, with vb_addr equal to its line address (offset bits 0).
- R4: A store with req_spec=1 leaves its line valid, dirty and speculative. A store with req_spec=0 does not clear an existing speculative flag.
- R5: When a speculative store hits a dirty, non-speculative line, the old data and line address appear on the eviction port in the response cycle, and the line then holds the new data.
- R6: A speculative store that hits a line that is already speculative produces no eviction.
- R7: Commit clears every speculative flag. The lines stay valid and dirty, so a later speculative store to such a line evicts the committed data.
- R8: Rollback invalidates every speculative line in every set. Non-speculative lines keep their tag, data and dirty state.
- R9: When a store misses and every way of the set is speculative, the response cycle shows overflow=1, rsp_hit=0 and vb_valid=0. All speculative lines in the cache are invalidated, as on a rollback, and nothing is installed.
- R10: A request in the same cycle as commit or rollback is dropped and gives rsp_valid=0. If commit and rollback arrive together, rollback takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_we | input | 1 | 1 for store, 0 for load |
| req_spec | input | 1 | Store belongs to an open atomic region |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data |
| commit | input | 1 | Flash commit of all speculative lines |
| rollback | input | 1 | Flash invalidate of all speculative lines |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_hit | output | 1 | Request found its line |
| rsp_rdata | output | DATA_W | Load data on a hit, else 0 |
| vb_valid | output | 1 | Eviction port write strobe |
| vb_addr | output | ADDR_W | Line address of the evicted data |
| vb_data | output | DATA_W | Evicted data |
| overflow | output | 1 | Store could not find a replaceable way; speculative lines dropped |

## Verification
The bench builds the tracker with 2 sets, 4 ways, 32-byte lines, a 12-bit address and 16-bit data. With these values a handful of tags fill a whole set, so the replacement order, way exhaustion, overflow recovery and the interplay between the two sets come up often. A long pseudo-random stream of loads, speculative and plain stores, commits and rollbacks, using eight tags, is compared every cycle against an arithmetic model of the requirements. Directed sequences with hand-derived values cover eviction before overwrite, commit followed by re-speculation, and the strobe collisions.

// File: rtl/spec_pkg.sv
package spec_pkg;

    typedef struct packed {
        logic valid;
        logic dirty;
        logic spec;
    } line_flags_t;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_ROLLBACK,
        ACT_COMMIT,
        ACT_LOAD,
        ACT_STORE
    } action_e;

endpackage

// File: rtl/spec_tag_match.sv
module spec_tag_match
    import spec_pkg::*;
#(
    parameter int WAYS  = 8,
    parameter int TAG_W = 23,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  line_flags_t [WAYS-1:0]            flags,
    input  logic        [WAYS-1:0][TAG_W-1:0] tags,
    input  logic        [TAG_W-1:0]           look_tag,
    output logic                              hit,
    output logic        [WAY_W-1:0]           hit_way
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = flags[w].valid && (tags[w] == look_tag);
    end

    always_comb begin
        hit     = |match;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = w[WAY_W-1:0];
        end
    end
endmodule

// File: rtl/spec_way_pick.sv
module spec_way_pick
    import spec_pkg::*;
#(
    parameter int WAYS = 8,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  line_flags_t [WAYS-1:0] flags,
    output logic                   pick_ok,
    output logic [WAY_W-1:0]       pick_way
);
    logic [WAYS-1:0] free_v;
    logic [WAYS-1:0] plain_v;

    for (genvar w = 0; w < WAYS; w++) begin : g_cls
        assign free_v[w]  = !flags[w].valid;
        assign plain_v[w] = !flags[w].spec;
    end

    always_comb begin
        pick_ok  = |plain_v;
        pick_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (plain_v[w]) pick_way = w[WAY_W-1:0];
        end
        if (|free_v) begin
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (free_v[w]) pick_way = w[WAY_W-1:0];
            end
        end
    end
endmodule

// File: rtl/spec_line_tracker.sv
module spec_line_tracker
    import spec_pkg::*;
#(
    parameter int SETS       = 16,
    parameter int WAYS       = 8,
    parameter int LINE_BYTES = 32,
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic              req_spec,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              commit,
    input  logic              rollback,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              vb_valid,
    output logic [ADDR_W-1:0] vb_addr,
    output logic [DATA_W-1:0] vb_data,
    output logic              overflow
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    typedef struct packed {
        line_flags_t [SETS-1:0][WAYS-1:0]             flg;
        logic        [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag;
        logic        [SETS-1:0][WAYS-1:0][DATA_W-1:0] dat;
        logic                                         rsp_valid;
        logic                                         rsp_hit;
        logic        [DATA_W-1:0]                     rsp_rdata;
        logic                                         vb_valid;
        logic        [ADDR_W-1:0]                     vb_addr;
        logic        [DATA_W-1:0]                     vb_data;
        logic                                         overflow;
    } state_t;

    state_t st_d, st_q;

    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag_in;
    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic             pick_ok;
    logic [WAY_W-1:0] pick_way;
    action_e          act;

    assign idx    = req_addr[OFF_W +: IDX_W];
    assign tag_in = req_addr[ADDR_W-1 -: TAG_W];

    spec_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .flags    (st_q.flg[idx]),
        .tags     (st_q.tag[idx]),
        .look_tag (tag_in),
        .hit      (hit),
        .hit_way  (hit_way)
    );

    spec_way_pick #(.WAYS(WAYS)) u_pick (
        .flags    (st_q.flg[idx]),
        .pick_ok  (pick_ok),
        .pick_way (pick_way)
    );

    always_comb begin
        if (rollback)                act = ACT_ROLLBACK;
        else if (commit)             act = ACT_COMMIT;
        else if (req_valid && req_we) act = ACT_STORE;
        else if (req_valid)          act = ACT_LOAD;
        else                         act = ACT_IDLE;
    end

    function automatic state_t drop_spec(state_t s);
        state_t r = s;
        for (int i = 0; i < SETS; i++) begin
            for (int w = 0; w < WAYS; w++) begin
                if (r.flg[i][w].spec) r.flg[i][w] = '0;
            end
        end
        return r;
    endfunction

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        st_d.rsp_hit   = 1'b0;
        st_d.rsp_rdata = '0;
        st_d.vb_valid  = 1'b0;
        st_d.vb_addr   = '0;
        st_d.vb_data   = '0;
        st_d.overflow  = 1'b0;
        unique case (act)
            ACT_ROLLBACK: st_d = drop_spec(st_d);
            ACT_COMMIT: begin
                for (int i = 0; i < SETS; i++) begin
                    for (int w = 0; w < WAYS; w++) st_d.flg[i][w].spec = 1'b0;
                end
            end
            ACT_LOAD: begin
                st_d.rsp_valid = 1'b1;
                if (hit) begin
                    st_d.rsp_hit   = 1'b1;
                    st_d.rsp_rdata = st_q.dat[idx][hit_way];
                end
            end
            ACT_STORE: begin
                st_d.rsp_valid = 1'b1;
                if (hit) begin
                    st_d.rsp_hit = 1'b1;
                    if (req_spec && st_q.flg[idx][hit_way].dirty && !st_q.flg[idx][hit_way].spec) begin
                        st_d.vb_valid = 1'b1;
                        st_d.vb_addr  = {st_q.tag[idx][hit_way], idx, {OFF_W{1'b0}}};
                        st_d.vb_data  = st_q.dat[idx][hit_way];
                    end
                    st_d.dat[idx][hit_way]       = req_wdata;
                    st_d.flg[idx][hit_way].dirty = 1'b1;
                    st_d.flg[idx][hit_way].spec  = st_q.flg[idx][hit_way].spec | req_spec;
                end else if (pick_ok) begin
                    if (st_q.flg[idx][pick_way].valid && st_q.flg[idx][pick_way].dirty) begin
                        st_d.vb_valid = 1'b1;
                        st_d.vb_addr  = {st_q.tag[idx][pick_way], idx, {OFF_W{1'b0}}};
                        st_d.vb_data  = st_q.dat[idx][pick_way];
                    end
                    st_d.tag[idx][pick_way] = tag_in;
                    st_d.dat[idx][pick_way] = req_wdata;
                    st_d.flg[idx][pick_way] = '{valid: 1'b1, dirty: 1'b1, spec: req_spec};
                end else begin
                    st_d.overflow = 1'b1;
                    st_d          = drop_spec(st_d);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_hit   = st_q.rsp_hit;
    assign rsp_rdata = st_q.rsp_rdata;
    assign vb_valid  = st_q.vb_valid;
    assign vb_addr   = st_q.vb_addr;
    assign vb_data   = st_q.vb_data;
    assign overflow  = st_q.overflow;
endmodule

// File: rtl/spec_line_tracker_chk.sv
module spec_line_tracker_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_we,
    input logic              commit,
    input logic              rollback,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              vb_valid,
    input logic              overflow
);
    // R10: a response exists only for an undisturbed request
    p_rsp_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !commit && !rollback));

    // R10: strobes drop the request
    p_strobe_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(commit || rollback) |-> !rsp_valid);

    // R3: eviction only as the result of a store
    p_evict_from_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vb_valid |-> (rsp_valid && $past(req_we)));

    // R9: overflow follows a store miss and never evicts
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (rsp_valid && !rsp_hit && !vb_valid && $past(req_we)));

    // R2: loads never evict and misses return zero
    p_load_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !$past(req_we)) |-> (!vb_valid && !overflow && (rsp_hit || rsp_rdata == '0)));
endmodule

bind spec_line_tracker spec_line_tracker_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_we    (req_we),
    .commit    (commit),
    .rollback  (rollback),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_rdata (rsp_rdata),
    .vb_valid  (vb_valid),
    .overflow  (overflow)
);

// File: tb/sim_spec_line_tracker.sv
module sim_spec_line_tracker;
    localparam int NS  = 2;
    localparam int NW  = 4;
    localparam int LB  = 32;
    localparam int AW  = 12;
    localparam int DW  = 16;
    localparam int OFF = 5;
    localparam int TW  = AW - OFF - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_we = 1'b0, req_spec = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          commit = 1'b0, rollback = 1'b0;
    logic          rsp_valid, rsp_hit, vb_valid, overflow;
    logic [DW-1:0] rsp_rdata, vb_data;
    logic [AW-1:0] vb_addr;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    spec_line_tracker #(.SETS(NS), .WAYS(NW), .LINE_BYTES(LB), .ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we), .req_spec(req_spec),
        .req_addr(req_addr), .req_wdata(req_wdata), .commit(commit), .rollback(rollback),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
        .vb_valid(vb_valid), .vb_addr(vb_addr), .vb_data(vb_data), .overflow(overflow)
    );

    // model state
    bit            mv [NS][NW];
    bit            md [NS][NW];
    bit            ms [NS][NW];
    logic [TW-1:0] mt [NS][NW];
    logic [DW-1:0] mx [NS][NW];

    logic          e_rv, e_hit, e_vb, e_ov;
    logic [DW-1:0] e_rd, e_vd;
    logic [AW-1:0] e_va;

    function automatic logic [AW-1:0] mk(input int tg, input int s, input int off);
        return {tg[TW-1:0], s[0], off[OFF-1:0]};
    endfunction

    task automatic model_drop();
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++)
                if (ms[s][w]) begin mv[s][w] = 0; md[s][w] = 0; ms[s][w] = 0; end
    endtask

    task automatic model_step(input logic v, we, sp, cm, rb, input logic [AW-1:0] a, input logic [DW-1:0] wd);
        int s, h, p;
        logic [TW-1:0] tg;
        s = int'(a[OFF]);
        tg = a[AW-1:OFF+1];
        e_rv = 0; e_hit = 0; e_vb = 0; e_ov = 0; e_rd = '0; e_vd = '0; e_va = '0;
        if (rb) model_drop();
        else if (cm) begin
            for (int i = 0; i < NS; i++) for (int w = 0; w < NW; w++) ms[i][w] = 0;
        end else if (v) begin
            e_rv = 1;
            h = -1;
            for (int w = NW - 1; w >= 0; w--) if (mv[s][w] && mt[s][w] == tg) h = w;
            if (!we) begin
                if (h >= 0) begin e_hit = 1; e_rd = mx[s][h]; end
            end else if (h >= 0) begin
                e_hit = 1;
                if (sp && md[s][h] && !ms[s][h]) begin
                    e_vb = 1; e_vd = mx[s][h]; e_va = {mt[s][h], s[0], {OFF{1'b0}}};
                end
                mx[s][h] = wd; md[s][h] = 1; if (sp) ms[s][h] = 1;
            end else begin
                p = -1;
                for (int w = NW - 1; w >= 0; w--) if (!ms[s][w]) p = w;
                for (int w = NW - 1; w >= 0; w--) if (!mv[s][w]) p = w;
                if (p < 0) begin
                    e_ov = 1; model_drop();
                end else begin
                    if (mv[s][p] && md[s][p]) begin
                        e_vb = 1; e_vd = mx[s][p]; e_va = {mt[s][p], s[0], {OFF{1'b0}}};
                    end
                    mv[s][p] = 1; md[s][p] = 1; ms[s][p] = sp; mt[s][p] = tg; mx[s][p] = wd;
                end
            end
        end
    endtask

    task automatic op(input logic v, we, sp, cm, rb, input logic [AW-1:0] a,
                      input logic [DW-1:0] wd, input string rq);
        @(negedge clk);
        req_valid = v; req_we = we; req_spec = sp; commit = cm; rollback = rb;
        req_addr = a; req_wdata = wd;
        model_step(v, we, sp, cm, rb, a, wd);
        @(posedge clk);
        #2;
        total++;
        if (rsp_valid !== e_rv || rsp_hit !== e_hit || rsp_rdata !== e_rd ||
            vb_valid !== e_vb || vb_addr !== e_va || vb_data !== e_vd || overflow !== e_ov) begin
            bad++;
            $display("FAIL %s: got rv=%b hit=%b rd=%h vb=%b va=%h vd=%h ov=%b exp rv=%b hit=%b rd=%h vb=%b va=%h vd=%h ov=%b",
                     rq, rsp_valid, rsp_hit, rsp_rdata, vb_valid, vb_addr, vb_data, overflow,
                     e_rv, e_hit, e_rd, e_vb, e_va, e_vd, e_ov);
        end
        req_valid = 0; req_we = 0; req_spec = 0; commit = 0; rollback = 0;
    endtask

    task automatic expect1(input logic got, input logic exp, input string rq);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %b exp %b", rq, got, exp);
        end
    endtask

    task automatic expectd(input logic [DW-1:0] got, input logic [DW-1:0] exp, input string rq);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h exp %h", rq, got, exp);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got hang exp completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) begin
                mv[s][w] = 0; md[s][w] = 0; ms[s][w] = 0; mt[s][w] = '0; mx[s][w] = '0;
            end
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state at the ports
        expect1(rsp_valid, 1'b0, "R1");
        expect1(vb_valid, 1'b0, "R1");
        expect1(overflow, 1'b0, "R1");
        @(negedge clk);
        rst_n = 1;
        op(1, 0, 0, 0, 0, mk(1, 0, 3), '0, "R1");
        expect1(rsp_hit, 1'b0, "R1");

        // R3: plain store, then R2 load hit ignoring offset
        op(1, 1, 0, 0, 0, mk(1, 0, 0), 16'hA001, "R3");
        op(1, 0, 0, 0, 0, mk(1, 0, 17), '0, "R2");
        expectd(rsp_rdata, 16'hA001, "R2");
        // R5: speculative overwrite evicts committed dirty data
        op(1, 1, 1, 0, 0, mk(1, 0, 0), 16'hB001, "R5");
        expect1(vb_valid, 1'b1, "R5");
        expectd(vb_data, 16'hA001, "R5");
        // R6: second speculative store, no eviction
        op(1, 1, 1, 0, 0, mk(1, 0, 0), 16'hC001, "R6");
        expect1(vb_valid, 1'b0, "R6");
        // R2: speculative data is visible
        op(1, 0, 0, 0, 0, mk(1, 0, 0), '0, "R2");
        expectd(rsp_rdata, 16'hC001, "R2");
        // R7: commit keeps line, later speculation evicts committed value
        op(0, 0, 0, 1, 0, '0, '0, "R7");
        op(1, 0, 0, 0, 0, mk(1, 0, 0), '0, "R7");
        expectd(rsp_rdata, 16'hC001, "R7");
        op(1, 1, 1, 0, 0, mk(1, 0, 0), 16'hD001, "R7");
        expectd(vb_data, 16'hC001, "R7");
        // R8: rollback drops speculative, keeps plain line in other set
        op(1, 1, 0, 0, 0, mk(2, 1, 0), 16'hE002, "R8");
        op(0, 0, 0, 0, 1, '0, '0, "R8");
        op(1, 0, 0, 0, 0, mk(1, 0, 0), '0, "R8");
        expect1(rsp_hit, 1'b0, "R8");
        op(1, 0, 0, 0, 0, mk(2, 1, 0), '0, "R8");
        expectd(rsp_rdata, 16'hE002, "R8");
        // R4: plain store keeps speculative flag (rollback removes it)
        op(1, 1, 1, 0, 0, mk(3, 1, 0), 16'h0303, "R4");
        op(1, 1, 0, 0, 0, mk(3, 1, 0), 16'h0304, "R4");
        op(0, 0, 0, 0, 1, '0, '0, "R4");
        op(1, 0, 0, 0, 0, mk(3, 1, 0), '0, "R4");
        expect1(rsp_hit, 1'b0, "R4");
        // R9: fill set 0 with speculative lines, then overflow
        for (int t = 10; t < 10 + NW; t++) op(1, 1, 1, 0, 0, mk(t, 0, 0), 16'(t), "R9");
        op(1, 1, 1, 0, 0, mk(20, 0, 0), 16'h2020, "R9");
        expect1(overflow, 1'b1, "R9");
        op(1, 0, 0, 0, 0, mk(10, 0, 0), '0, "R9");
        expect1(rsp_hit, 1'b0, "R9");
        op(1, 0, 0, 0, 0, mk(2, 1, 0), '0, "R9");
        expect1(rsp_hit, 1'b1, "R9");
        // R10: request with strobes is dropped, rollback beats commit
        op(1, 1, 1, 0, 0, mk(5, 0, 0), 16'h0505, "R10");
        op(1, 1, 0, 1, 1, mk(6, 0, 0), 16'h0606, "R10");
        expect1(rsp_valid, 1'b0, "R10");
        op(1, 0, 0, 0, 0, mk(5, 0, 0), '0, "R10");
        expect1(rsp_hit, 1'b0, "R10");

        // sweep
        lf = 16'hACE1;
        for (int n = 0; n < 6000; n++) begin
            int k;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            k = int'(lf[3:0]);
            if (k == 0)
                op(lf[13], lf[14], 0, 1, 0, mk(int'(lf[6:4]), int'(lf[7]), int'(lf[12:8])), lf ^ 16'(n), "R7");
            else if (k == 1)
                op(lf[13], 1, 1, 0, 1, mk(int'(lf[6:4]), int'(lf[7]), 0), lf, "R8");
            else if (k < 7)
                op(1, 0, 0, 0, 0, mk(int'(lf[6:4]), int'(lf[7]), int'(lf[12:8])), '0, "R2");
            else if (k < 12)
                op(1, 1, 1, 0, 0, mk(int'(lf[6:4]), int'(lf[7]), int'(lf[12:8])), lf ^ 16'(n), "R4");
            else
                op(1, 1, 0, 0, 0, mk(int'(lf[6:4]), int'(lf[7]), int'(lf[12:8])), lf + 16'(n), "R3");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule